// File: doc/BRIEF.md
# Host-Driven Address Gate Bit Controller

This block lets a host processor set or clear one port output bit, the gate line that masks a memory address bit, by writing a short command sequence into the controller's host interface. No firmware on the internal processor takes part. Before it is armed, the bit is an ordinary port bit that the internal processor writes. A one-cycle enable pulse from the internal side arms the feature. After that the bit is an output owned by the host side. Internal code can still read it, but its writes no longer reach it. The block stays armed until reset.

While armed, a sequence detector watches host writes. Each write is marked as command or data by a select line. A command write of D1h opens the sequence. The data write that follows loads bit 1 of its byte into the gate bit and closes the sequence. The detector also drives a flag that tells the neighbouring input-buffer logic to swallow the writes it has handled, so the internal processor never sees them as buffered input. A different command arriving in the middle of a sequence cancels it and is left to normal handling.

Top module: `hgate_ctrl`

## Requirements
- R1: After reset the gate bit is 1, the block is disarmed (`armed_o` is 0), and the detector is idle.
- R2: While disarmed, an internal write (`cpu_we` high at a clock edge) loads `cpu_wd` into the gate bit at that edge. Host writes do not change the bit and never raise `suppress_ibf`.
- R3: A high `arm_pulse` at a clock edge sets `armed_o` at that edge. It stays set until the next reset, whatever else happens.
- R4: While armed, internal writes have no effect on the gate bit.
- R5: While armed, a host command write of D1h (`host_cmd`=1) followed by a host data write (`host_cmd`=0) loads bit 1 of the data byte into the gate bit. The load happens at the clock edge that ends the first cycle in which the data write's strobe is seen high, so within two clocks of the strobe rising.
- R6: While a sequence is open, a host command write of any value other than D1h cancels the sequence. The gate bit is unchanged and `suppress_ibf` stays low for that write.
- R7: `suppress_ibf` is high, only while armed, during the cycle in which a handled write is detected. A handled write is a D1h command, or the data write that completes an open sequence.
- R8: A host data write with no open sequence has no effect on the gate bit and does not raise `suppress_ibf`.
- R9: A D1h command that arrives while a sequence is already open keeps the sequence open and is itself suppressed.
- R10: A host write is one rising edge of `host_wr`. A strobe held high for several cycles counts as a single write, and `suppress_ibf` is high only in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, level, sampled on the clock |
| host_cmd | input | 1 | 1: the write is a command, 0: the write is data |
| host_data | input | 8 | Host data bus |
| arm_pulse | input | 1 | Enable pulse from the internal processor |
| cpu_we | input | 1 | Internal port write enable for the gate bit |
| cpu_wd | input | 1 | Internal port write value |
| gate_o | output | 1 | Gate bit, also the value internal code reads back |
| armed_o | output | 1 | Feature armed, so the pin is a dedicated output |
| suppress_ibf | output | 1 | Tells the input-buffer logic not to flag this host write |

## Verification
The checker tests on every cycle the properties that can be stated locally:
- armed stays set;
- while armed, the gate bit holds except on a sequence load;
- a load copies bit 1 of the data byte;
- a cancelling command leaves the bit alone;
- suppression never happens while disarmed;
- a data write with no open sequence is ignored;
- a held strobe makes only one event.

Only the bench scenarios can show that whole sequences give the right end value. They sweep every data byte through a complete sequence and every cancelling command byte through an open one. They also cover the disarmed port behaviour and re-arming across a second reset.

// File: rtl/hgate_pkg.sv
package hgate_pkg;
  localparam int HG_BYTE_W = 8;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

  function automatic logic hg_match(input logic [HG_BYTE_W-1:0] b,
                                    input logic [HG_BYTE_W-1:0] code);
    return (b == code);
  endfunction

  function automatic logic hg_pick(input logic [HG_BYTE_W-1:0] b,
                                   input int unsigned idx);
    return b[idx];
  endfunction
endpackage

// File: rtl/hgate_wr_edge.sv
module hgate_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic evt_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign evt_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/hgate_arm.sv
module hgate_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_o <= 1'b0;
    else if (arm_i) armed_o <= 1'b1;
  end
endmodule

// File: rtl/hgate_seq.sv
module hgate_seq
  import hgate_pkg::*;
#(
  parameter logic [HG_BYTE_W-1:0] GATE_CMD = 8'hD1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed_i,
  input  logic                 evt_i,
  input  logic                 is_cmd_i,
  input  logic [HG_BYTE_W-1:0] data_i,
  output logic                 load_o,
  output logic                 abort_o,
  output logic                 open_o,
  output logic                 suppress_o,
  output seq_state_t           state_o
);
  seq_state_t state_q, state_d;
  logic cmd_hit;

  assign cmd_hit = hg_match(data_i, GATE_CMD);
  assign open_o  = armed_i & evt_i & is_cmd_i & cmd_hit;
  assign load_o  = armed_i & evt_i & ~is_cmd_i & (state_q == SEQ_WAIT);
  assign abort_o = armed_i & evt_i & is_cmd_i & ~cmd_hit & (state_q == SEQ_WAIT);
  assign suppress_o = open_o | load_o;

  always_comb begin
    state_d = state_q;
    if (open_o)                 state_d = SEQ_WAIT;
    else if (load_o || abort_o) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hgate_port_bit.sv
module hgate_port_bit
  import hgate_pkg::*;
#(
  parameter int unsigned GATE_BIT  = 1,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 armed_i,
  input  logic                 cpu_we_i,
  input  logic                 cpu_wd_i,
  input  logic                 host_load_i,
  input  logic [HG_BYTE_W-1:0] host_data_i,
  output logic                 gate_o
);
  logic gate_q, gate_d;

  always_comb begin
    gate_d = gate_q;
    if (armed_i) begin
      if (host_load_i) gate_d = hg_pick(host_data_i, GATE_BIT);
    end else if (cpu_we_i) begin
      gate_d = cpu_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= RESET_VAL;
    else        gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hgate_ctrl.sv
module hgate_ctrl
  import hgate_pkg::*;
#(
  parameter logic [HG_BYTE_W-1:0] GATE_CMD  = 8'hD1,
  parameter int unsigned          GATE_BIT  = 1,
  parameter logic                 RESET_VAL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_cmd,
  input  logic [HG_BYTE_W-1:0] host_data,
  input  logic                 arm_pulse,
  input  logic                 cpu_we,
  input  logic                 cpu_wd,
  output logic                 gate_o,
  output logic                 armed_o,
  output logic                 suppress_ibf
);
  logic       wr_evt;
  logic       seq_load;
  logic       seq_abort;
  logic       seq_open;
  seq_state_t seq_state;

  hgate_wr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_i(host_wr), .evt_o(wr_evt)
  );

  hgate_arm u_arm (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_pulse), .armed_o(armed_o)
  );

  hgate_seq #(.GATE_CMD(GATE_CMD)) u_seq (
    .clk(clk), .rst_n(rst_n), .armed_i(armed_o), .evt_i(wr_evt),
    .is_cmd_i(host_cmd), .data_i(host_data), .load_o(seq_load),
    .abort_o(seq_abort), .open_o(seq_open), .suppress_o(suppress_ibf),
    .state_o(seq_state)
  );

  hgate_port_bit #(.GATE_BIT(GATE_BIT), .RESET_VAL(RESET_VAL)) u_port (
    .clk(clk), .rst_n(rst_n), .armed_i(armed_o), .cpu_we_i(cpu_we),
    .cpu_wd_i(cpu_wd), .host_load_i(seq_load), .host_data_i(host_data),
    .gate_o(gate_o)
  );
endmodule

// File: rtl/hgate_ctrl_chk.sv
module hgate_ctrl_chk
  import hgate_pkg::*;
#(
  parameter int unsigned GATE_BIT  = 1,
  parameter logic        RESET_VAL = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_wr,
  input logic                 host_cmd,
  input logic [HG_BYTE_W-1:0] host_data,
  input logic                 gate_o,
  input logic                 armed_o,
  input logic                 suppress_ibf,
  input logic                 wr_evt,
  input logic                 seq_load,
  input logic                 seq_abort,
  input seq_state_t           seq_state
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (gate_o == RESET_VAL && !armed_o && seq_state == SEQ_IDLE)); // R1

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o); // R3

  AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !seq_load) |=> $stable(gate_o)); // R4

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_load |=> (gate_o == $past(host_data[GATE_BIT]))); // R5

  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> ($stable(gate_o) && seq_state == SEQ_IDLE)); // R6

  AST_ABORT_NO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> !suppress_ibf); // R6

  AST_SUPPRESS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_ibf |-> (armed_o && wr_evt)); // R7

  AST_IDLE_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !host_cmd && seq_state == SEQ_IDLE) |-> (!seq_load && !suppress_ibf)); // R8

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wr_evt) |=> !wr_evt); // R10
endmodule

bind hgate_ctrl hgate_ctrl_chk #(.GATE_BIT(GATE_BIT), .RESET_VAL(RESET_VAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cmd(host_cmd),
  .host_data(host_data), .gate_o(gate_o), .armed_o(armed_o),
  .suppress_ibf(suppress_ibf), .wr_evt(wr_evt), .seq_load(seq_load),
  .seq_abort(seq_abort), .seq_state(seq_state)
);

// File: tb/hgate_ctrl_tb_top.sv
module hgate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CMD_GATE = 8'hD1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_cmd = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       arm_pulse = 1'b0;
  logic       cpu_we = 1'b0;
  logic       cpu_wd = 1'b0;
  logic       gate_o, armed_o, suppress_ibf;

  int checks = 0;
  int fails  = 0;
  logic exp_gate;
  logic sup_seen;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hgate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cmd(host_cmd),
    .host_data(host_data), .arm_pulse(arm_pulse), .cpu_we(cpu_we),
    .cpu_wd(cpu_wd), .gate_o(gate_o), .armed_o(armed_o),
    .suppress_ibf(suppress_ibf)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One host write: the strobe goes high at a falling edge for HOLD cycles.
  // sup_seen holds suppress_ibf as seen in the first cycle.
  task automatic host_write(input logic cmd, input logic [7:0] d, input int hold);
    @(negedge clk);
    host_wr = 1'b1; host_cmd = cmd; host_data = d;
    #1 sup_seen = suppress_ibf;
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      #1 check("R10 no suppress on held strobe", suppress_ibf, 1'b0);
    end
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic v);
    @(negedge clk);
    cpu_we = 1'b1; cpu_wd = v;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gate after reset", gate_o, 1'b1);
    check("R1 disarmed after reset", armed_o, 1'b0);

    // Disarmed: internal processor owns the bit
    cpu_write(1'b0);
    check("R2 cpu write 0", gate_o, 1'b0);
    host_write(1'b1, CMD_GATE, 1);
    check("R2 no suppress disarmed", sup_seen, 1'b0);
    host_write(1'b0, 8'h02, 1);
    check("R2 no suppress disarmed data", sup_seen, 1'b0);
    check("R2 host ignored disarmed", gate_o, 1'b0);
    cpu_write(1'b1);
    check("R2 cpu write 1", gate_o, 1'b1);

    // Arm
    @(negedge clk); arm_pulse = 1'b1;
    @(negedge clk); arm_pulse = 1'b0;
    check("R3 armed", armed_o, 1'b1);
    cpu_write(1'b0);
    check("R4 cpu write ignored", gate_o, 1'b1);
    exp_gate = 1'b1;

    // Full sequence sweep over every data byte
    for (int d = 0; d < 256; d++) begin
      host_write(1'b1, CMD_GATE, 1);
      check("R7 suppress on gate command", sup_seen, 1'b1);
      host_write(1'b0, 8'(d), 1);
      check("R7 suppress on data", sup_seen, 1'b1);
      exp_gate = d[1];
      check("R5 gate from data bit 1", gate_o, exp_gate);
    end

    // Abort sweep over every other command byte
    for (int c = 0; c < 256; c++) begin
      if (8'(c) == CMD_GATE) continue;
      host_write(1'b1, CMD_GATE, 1);
      host_write(1'b0, 8'h00, 1);
      exp_gate = 1'b0;
      host_write(1'b1, CMD_GATE, 1);
      host_write(1'b1, 8'(c), 1);
      check("R6 abort not suppressed", sup_seen, 1'b0);
      check("R6 abort keeps gate", gate_o, exp_gate);
      host_write(1'b0, 8'h02, 1);
      check("R8 idle data not suppressed", sup_seen, 1'b0);
      check("R8 idle data ignored", gate_o, exp_gate);
    end

    // Repeated gate command keeps the sequence open
    host_write(1'b1, CMD_GATE, 1);
    host_write(1'b1, CMD_GATE, 1);
    check("R9 repeated command suppressed", sup_seen, 1'b1);
    host_write(1'b0, 8'h02, 1);
    check("R9 data after repeat suppressed", sup_seen, 1'b1);
    check("R9 gate after repeat", gate_o, 1'b1);

    // Held strobes count once
    host_write(1'b1, CMD_GATE, 4);
    check("R10 held command suppressed once", sup_seen, 1'b1);
    host_write(1'b0, 8'h00, 4);
    check("R10 held data suppressed once", sup_seen, 1'b1);
    check("R10 gate after held data", gate_o, 1'b0);
    host_write(1'b0, 8'h02, 1);
    check("R10 second data not a sequence", gate_o, 1'b0);

    // Load timing: gate updates at the edge ending the first strobe cycle
    host_write(1'b1, CMD_GATE, 1);
    @(negedge clk);
    host_wr = 1'b1; host_cmd = 1'b0; host_data = 8'h02;
    @(negedge clk);
    check("R5 load within one edge", gate_o, 1'b1);
    host_wr = 1'b0;
    @(negedge clk);

    // Re-arm is harmless; reset disarms
    @(negedge clk); arm_pulse = 1'b1;
    @(negedge clk); arm_pulse = 1'b0;
    check("R3 still armed", armed_o, 1'b1);
    host_write(1'b1, CMD_GATE, 1);
    host_write(1'b0, 8'h00, 1);
    check("R3 gate cleared before reset", gate_o, 1'b0);
    do_reset();
    check("R1 gate after second reset", gate_o, 1'b1);
    check("R3 disarmed by reset", armed_o, 1'b0);
    cpu_write(1'b0);
    check("R2 cpu owns bit after reset", gate_o, 1'b0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule